// File: doc/BRIEF.md
# Arbitrated Bus Master Bid and Cycle Controller

This block sits between a device's local logic and a shared, arbitrated processor bus. When the local side presents a request, the controller bids for the bus by raising its own request line. It does this only when the device is unlocked, no other grant is showing on the bus and bus reset is inactive. It then waits for the arbiter to grant it the bus. Once it owns the bus, it runs one of three basic cycles. A Read has an address phase followed by a data phase in which the slave returns data. A Write has an address phase followed by a data phase in which the master drives data. A Vector has only an address phase. As an alternative to any cycle, the controller can flag an interrupt to the arbiter.

Every cycle is issued in one of two release variants, and the variants differ only in when the bus is given back. After a Hold cycle, the bus is kept for further cycles without a new bid, but a release request from the arbiter is obeyed. After a Retain cycle, a release request is ignored, so the next cycle of an indivisible sequence (for example read-modify-write) follows with no foreign cycle in between. If the arbiter asserts abort during a data phase, the cycle ends at once and the bus is dropped. The state machine has six states. IDLE waits. BID drives the request line. GRANTED holds the bus with no cycle running. ADDR is the addressing phase. DATA is the data phase. RELEASE gives up the bus.

The transitions are as follows. IDLE goes to BID when the bid is allowed. BID goes to GRANTED on grant. GRANTED goes to ADDR when a request is pending. GRANTED goes to RELEASE on a release request when no retain is in force. ADDR goes to DATA for Read and Write. At the end of a cycle, meaning ADDR for Vector and interrupt or DATA on acknowledge, the controller goes to RELEASE, ADDR or GRANTED. DATA goes to RELEASE on abort. RELEASE goes to IDLE.

Top module: `bus_master_ctrl`

## Requirements
- R1: During and directly after reset the controller is in IDLE. bid_o, own_bus_o, addr_stb_o, data_stb_o, irq_o and rsp_valid_o are all 0.
- R2: In IDLE with req_valid_i high, bid_o rises one cycle later only if lock_i, busgr_i and bus_rst_i are all 0. While any of them is 1 the controller stays in IDLE. Once raised, bid_o stays high until grant_i is seen.
- R3: grant_i in BID moves to GRANTED: own_bus_o is 1 and bid_o is 0. A pending request in GRANTED is accepted: req_ready_o is 1 in that cycle and the addressing phase follows in the next cycle.
- R4: In the addressing phase the request fields are latched. For a Read (req_kind_i=0), Write (1) or Vector (2), addr_stb_o is 1, hwy_o carries the address and cyc_kind_o shows the kind. Read and Write enter the data phase in the next cycle.
- R5: In the data phase data_stb_o is 1, and hwy_o carries the write data for a Write and 0 for a Read. The phase lasts until ack_i. The cycle after the acknowledge, rsp_valid_o is 1 and rsp_data_o holds rdata_i for a Read and 0 for a Write.
- R6: A Vector cycle has no data phase: rsp_valid_o is 1 in the cycle after the addressing phase, and data_stb_o stays 0.
- R7: An interrupt request (req_kind_i=3) raises irq_o for one cycle in place of the addressing phase, with addr_stb_o 0 and hwy_o 0. It completes like a Vector cycle.
- R8: After a Hold cycle (req_retain_i=0), release_req_i high sends the controller to RELEASE (own_bus_o 0) and then to IDLE. Otherwise the bus stays owned, and a further request goes straight to the addressing phase with bid_o remaining 0.
- R9: After a Retain cycle (req_retain_i=1), release_req_i is ignored and own_bus_o stays 1 until the next request has run. The release is honoured once a Hold cycle completes.
- R10: abort_i high during the data phase ends the cycle. In the next cycle own_bus_o is 0, rsp_valid_o is 1 and rsp_abort_o is 1, and IDLE follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the controller |
| req_valid_i | input | 1 | Local request pending |
| req_kind_i | input | 2 | 0 Read, 1 Write, 2 Vector, 3 interrupt |
| req_retain_i | input | 1 | 1 Retain variant, 0 Hold variant |
| req_addr_i | input | HW_W | Address of the cycle |
| req_wdata_i | input | HW_W | Write data |
| req_ready_o | output | 1 | Request accepted this cycle |
| lock_i | input | 1 | Device locked, bidding forbidden |
| busgr_i | input | 1 | Bus grant line active on the bus |
| bus_rst_i | input | 1 | Bus reset line active |
| grant_i | input | 1 | Arbiter grants this master |
| release_req_i | input | 1 | Arbiter asks for the bus back |
| abort_i | input | 1 | Arbiter aborts the running cycle |
| ack_i | input | 1 | Slave acknowledge of the data phase |
| rdata_i | input | HW_W | Read data from the slave |
| bid_o | output | 1 | Own request line |
| own_bus_o | output | 1 | Master holds the bus |
| addr_stb_o | output | 1 | Addressing phase strobe |
| data_stb_o | output | 1 | Data phase strobe |
| irq_o | output | 1 | Interrupt flag to the arbiter |
| cyc_kind_o | output | 2 | Kind of the latched cycle |
| hwy_o | output | HW_W | Multiplexed address/data highway |
| rsp_valid_o | output | 1 | Cycle finished |
| rsp_data_o | output | HW_W | Read data of the finished cycle |
| rsp_abort_o | output | 1 | Finished cycle was aborted |

## Verification
The hardest state to reach is GRANTED with a retain in force while the arbiter is asking for the bus. The only visible sign that the release is being refused is that own_bus_o does not drop. To get there, the bench runs every cycle kind in both variants with release_req_i raised during the addressing phase. In the Retain runs it then holds release_req_i for several idle cycles, and finally issues a Hold cycle that must end in RELEASE. Each fresh bid also first sweeps all seven gating combinations of lock, grant and bus reset before the bid is allowed through.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
    typedef enum logic [1:0] {
        K_READ   = 2'd0,
        K_WRITE  = 2'd1,
        K_VECTOR = 2'd2,
        K_IRQ    = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_BID     = 3'd1,
        S_GRANTED = 3'd2,
        S_ADDR    = 3'd3,
        S_DATA    = 3'd4,
        S_RELEASE = 3'd5
    } state_e;
endpackage

// File: rtl/bmc_bid_gate.sv
module bmc_bid_gate (
    input  logic req_valid_i,
    input  logic lock_i,
    input  logic busgr_i,
    input  logic bus_rst_i,
    output logic bid_ok_o
);
    // A bid needs local demand and every bus status line quiet.
    always_comb begin
        bid_ok_o = req_valid_i & ~lock_i & ~busgr_i & ~bus_rst_i;
    end
endmodule

// File: rtl/bmc_datapath.sv
module bmc_datapath
    import bmc_pkg::*;
#(
    parameter int HW_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [1:0]      req_kind_i,
    input  logic            req_retain_i,
    input  logic [HW_W-1:0] req_addr_i,
    input  logic [HW_W-1:0] req_wdata_i,
    input  logic            addr_phase_i,
    input  logic            data_phase_i,
    input  logic            done_i,
    input  logic            aborted_i,
    input  logic [HW_W-1:0] rdata_i,
    output kind_e           cur_kind_o,
    output logic            cur_retain_o,
    output logic [HW_W-1:0] hwy_o,
    output logic            rsp_valid_o,
    output logic [HW_W-1:0] rsp_data_o,
    output logic            rsp_abort_o
);
    logic [HW_W-1:0] addr_q;
    logic [HW_W-1:0] wdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_kind_o   <= K_READ;
            cur_retain_o <= 1'b0;
            addr_q       <= '0;
            wdata_q      <= '0;
        end else if (load_i) begin
            cur_kind_o   <= kind_e'(req_kind_i);
            cur_retain_o <= req_retain_i;
            addr_q       <= req_addr_i;
            wdata_q      <= req_wdata_i;
        end
    end

    // Highway multiplex: address first, then write data.
    always_comb begin
        hwy_o = '0;
        if (addr_phase_i && cur_kind_o != K_IRQ) begin
            hwy_o = addr_q;
        end else if (data_phase_i && cur_kind_o == K_WRITE) begin
            hwy_o = wdata_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_o <= 1'b0;
            rsp_data_o  <= '0;
            rsp_abort_o <= 1'b0;
        end else begin
            rsp_valid_o <= done_i | aborted_i;
            rsp_abort_o <= aborted_i;
            rsp_data_o  <= (done_i && cur_kind_o == K_READ) ? rdata_i : '0;
        end
    end

    // R10: an aborted response never carries data
    p_abort_no_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_abort_o |-> (rsp_valid_o && rsp_data_o == '0));

    // R4: latched cycle fields do not move while a cycle is in flight
    p_fields_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_phase_i && !load_i) |=> (data_phase_i || $stable(addr_q)));
endmodule

// File: rtl/bus_master_ctrl.sv
module bus_master_ctrl
    import bmc_pkg::*;
#(
    parameter int HW_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid_i,
    input  logic [1:0]      req_kind_i,
    input  logic            req_retain_i,
    input  logic [HW_W-1:0] req_addr_i,
    input  logic [HW_W-1:0] req_wdata_i,
    output logic            req_ready_o,
    input  logic            lock_i,
    input  logic            busgr_i,
    input  logic            bus_rst_i,
    input  logic            grant_i,
    input  logic            release_req_i,
    input  logic            abort_i,
    input  logic            ack_i,
    input  logic [HW_W-1:0] rdata_i,
    output logic            bid_o,
    output logic            own_bus_o,
    output logic            addr_stb_o,
    output logic            data_stb_o,
    output logic            irq_o,
    output logic [1:0]      cyc_kind_o,
    output logic [HW_W-1:0] hwy_o,
    output logic            rsp_valid_o,
    output logic [HW_W-1:0] rsp_data_o,
    output logic            rsp_abort_o
);
    state_e state_q, state_d;
    logic   retained_q;
    logic   bid_ok;
    logic   cyc_end;
    logic   abort_end;
    logic   load;
    kind_e  cur_kind;
    logic   cur_retain;

    bmc_bid_gate u_gate (
        .req_valid_i (req_valid_i),
        .lock_i      (lock_i),
        .busgr_i     (busgr_i),
        .bus_rst_i   (bus_rst_i),
        .bid_ok_o    (bid_ok)
    );

    bmc_datapath #(.HW_W(HW_W)) u_dp (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load),
        .req_kind_i   (req_kind_i),
        .req_retain_i (req_retain_i),
        .req_addr_i   (req_addr_i),
        .req_wdata_i  (req_wdata_i),
        .addr_phase_i (state_q == S_ADDR),
        .data_phase_i (state_q == S_DATA),
        .done_i       (cyc_end),
        .aborted_i    (abort_end),
        .rdata_i      (rdata_i),
        .cur_kind_o   (cur_kind),
        .cur_retain_o (cur_retain),
        .hwy_o        (hwy_o),
        .rsp_valid_o  (rsp_valid_o),
        .rsp_data_o   (rsp_data_o),
        .rsp_abort_o  (rsp_abort_o)
    );

    always_comb begin
        cyc_end   = ((state_q == S_ADDR) && (cur_kind == K_VECTOR || cur_kind == K_IRQ))
                  || ((state_q == S_DATA) && ack_i && !abort_i);
        abort_end = (state_q == S_DATA) && abort_i;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (bid_ok) state_d = S_BID;
            S_BID:     if (grant_i) state_d = S_GRANTED;
            S_GRANTED: begin
                if (!retained_q && release_req_i) state_d = S_RELEASE;
                else if (req_valid_i)             state_d = S_ADDR;
            end
            S_ADDR: begin
                if (cur_kind == K_READ || cur_kind == K_WRITE) state_d = S_DATA;
            end
            S_DATA: begin
                if (abort_i) state_d = S_RELEASE;
            end
            S_RELEASE: state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
        if (cyc_end) begin
            if (!cur_retain && release_req_i) state_d = S_RELEASE;
            else if (req_valid_i)             state_d = S_ADDR;
            else                              state_d = S_GRANTED;
        end
        load = (state_d == S_ADDR);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            retained_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (cyc_end)                                   retained_q <= cur_retain;
            else if (abort_end || state_q == S_RELEASE)    retained_q <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        req_ready_o = load;
        bid_o       = (state_q == S_BID);
        own_bus_o   = (state_q == S_GRANTED) || (state_q == S_ADDR) || (state_q == S_DATA);
        addr_stb_o  = (state_q == S_ADDR) && (cur_kind != K_IRQ);
        irq_o       = (state_q == S_ADDR) && (cur_kind == K_IRQ);
        data_stb_o  = (state_q == S_DATA);
        cyc_kind_o  = cur_kind;
    end

    p_bid_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bid_o) |-> $past(req_valid_i && !lock_i && !busgr_i && !bus_rst_i));

    p_grant_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bid_o && grant_i) |=> (own_bus_o && !bid_o && !addr_stb_o));

    p_data_after_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_stb_o) |-> $past(addr_stb_o));

    p_wait_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_stb_o && !ack_i && !abort_i) |=> data_stb_o);

    p_vector_no_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_stb_o && cyc_kind_o == 2'd2) |=> (!data_stb_o && rsp_valid_o));

    p_irq_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (!addr_stb_o && !data_stb_o && hwy_o == '0));

    p_retain_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_GRANTED && retained_q) |=> own_bus_o);

    p_abort_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (data_stb_o && abort_i) |=> (!own_bus_o && rsp_abort_o));

    p_phase_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_stb_o, data_stb_o, irq_o, bid_o}));
endmodule

// File: tb/bus_master_ctrl_tb.sv
module bus_master_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HW_W = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [1:0]      req_kind = 2'd0;
    logic            req_retain = 1'b0;
    logic [HW_W-1:0] req_addr = '0;
    logic [HW_W-1:0] req_wdata = '0;
    logic            req_ready;
    logic            lock = 1'b0, busgr = 1'b0, bus_rst = 1'b0;
    logic            grant = 1'b0, release_req = 1'b0, abort_in = 1'b0, ack = 1'b0;
    logic [HW_W-1:0] rdata = '0;
    logic            bid, own_bus, addr_stb, data_stb, irq;
    logic [1:0]      cyc_kind;
    logic [HW_W-1:0] hwy;
    logic            rsp_valid;
    logic [HW_W-1:0] rsp_data;
    logic            rsp_abort;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_master_ctrl #(.HW_W(HW_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_kind_i(req_kind), .req_retain_i(req_retain),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_ready_o(req_ready),
        .lock_i(lock), .busgr_i(busgr), .bus_rst_i(bus_rst),
        .grant_i(grant), .release_req_i(release_req), .abort_i(abort_in), .ack_i(ack),
        .rdata_i(rdata),
        .bid_o(bid), .own_bus_o(own_bus), .addr_stb_o(addr_stb), .data_stb_o(data_stb),
        .irq_o(irq), .cyc_kind_o(cyc_kind), .hwy_o(hwy),
        .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_abort_o(rsp_abort)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Runs one cycle. fresh=1 starts in IDLE (bid first); else starts in GRANTED.
    task automatic do_cycle(input bit fresh, input int k, input bit ret, input bit rel,
                            input bit ab, input logic [HW_W-1:0] a,
                            input logic [HW_W-1:0] w, input logic [HW_W-1:0] r);
        req_kind = 2'(k); req_retain = ret; req_addr = a; req_wdata = w;
        req_valid = 1'b1;
        if (fresh) begin
            release_req = 1'b0;
            for (int g = 1; g < 8; g++) begin
                {lock, busgr, bus_rst} = 3'(g);
                tick();
                chk("R2 gated bid stays low", {31'd0, bid}, 32'd0);
            end
            {lock, busgr, bus_rst} = 3'd0;
            tick();
            chk("R2 bid raised", {31'd0, bid}, 32'd1);
            tick();
            chk("R2 bid held until grant", {31'd0, bid}, 32'd1);
            grant = 1'b1;
            tick();
            grant = 1'b0;
            chk("R3 own bus in GRANTED", {30'd0, own_bus, bid}, 32'd2);
        end
        #1;
        chk("R3 req_ready on accept", {31'd0, req_ready}, 32'd1);
        tick();
        req_valid = 1'b0;
        release_req = rel;
        chk("R8 no bid when reusing bus", {31'd0, bid}, 32'd0);
        chk("R4/R7 addr strobe", {31'd0, addr_stb}, (k != 3) ? 32'd1 : 32'd0);
        chk("R7 irq flag", {31'd0, irq}, (k == 3) ? 32'd1 : 32'd0);
        chk("R4 highway address", {16'd0, hwy}, (k == 3) ? 32'd0 : {16'd0, a});
        chk("R4 cycle kind", {30'd0, cyc_kind}, 32'(k));
        if (k < 2) begin
            tick();
            chk("R5 data strobe", {31'd0, data_stb}, 32'd1);
            chk("R5 highway data", {16'd0, hwy}, (k == 1) ? {16'd0, w} : 32'd0);
            tick();
            chk("R5 waits for ack", {31'd0, data_stb}, 32'd1);
            if (ab) begin
                abort_in = 1'b1;
                tick();
                abort_in = 1'b0;
                chk("R10 bus dropped on abort", {31'd0, own_bus}, 32'd0);
                chk("R10 abort response", {30'd0, rsp_valid, rsp_abort}, 32'd3);
                tick();
                chk("R10 back to IDLE", {30'd0, own_bus, bid}, 32'd0);
                return;
            end
            ack = 1'b1; rdata = r;
            tick();
            ack = 1'b0;
            chk("R5 response valid", {31'd0, rsp_valid}, 32'd1);
            chk("R5 response data", {16'd0, rsp_data}, (k == 0) ? {16'd0, r} : 32'd0);
            chk("R5 response not aborted", {31'd0, rsp_abort}, 32'd0);
        end else begin
            tick();
            chk("R6/R7 completes without data phase", {30'd0, rsp_valid, data_stb}, 32'd2);
            chk("R6 response data zero", {16'd0, rsp_data}, 32'd0);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset outputs",
            {26'd0, bid, own_bus, addr_stb, data_stb, irq, rsp_valid}, 32'd0);
        rst_n = 1'b1;
        tick();
        chk("R1 idle after reset", {30'd0, bid, own_bus}, 32'd0);

        for (int k = 0; k < 4; k++) begin
            for (int ret = 0; ret < 2; ret++) begin
                for (int rel = 0; rel < 2; rel++) begin
                    logic [HW_W-1:0] a = 16'h1000 + 16'(k * 16 + ret * 4 + rel);
                    logic [HW_W-1:0] w = 16'hA500 ^ a;
                    logic [HW_W-1:0] r = 16'h5A00 + a;
                    do_cycle(1'b1, k, ret[0], rel[0], 1'b0, a, w, r);
                    if (ret == 0 && rel == 1) begin
                        chk("R8 release after hold cycle", {31'd0, own_bus}, 32'd0);
                        tick();
                    end else if (ret == 0) begin
                        chk("R8 bus kept after hold cycle", {31'd0, own_bus}, 32'd1);
                        do_cycle(1'b0, 0, 1'b0, 1'b0, 1'b0, a + 1, w, r + 1);
                        chk("R8 still owned", {31'd0, own_bus}, 32'd1);
                        release_req = 1'b1;
                        tick();
                        chk("R8 release honoured", {31'd0, own_bus}, 32'd0);
                        release_req = 1'b0;
                        tick();
                    end else begin
                        chk("R9 bus kept after retain cycle", {31'd0, own_bus}, 32'd1);
                        release_req = 1'b1;
                        tick();
                        chk("R9 release ignored", {31'd0, own_bus}, 32'd1);
                        tick();
                        chk("R9 release still ignored", {31'd0, own_bus}, 32'd1);
                        do_cycle(1'b0, 1, 1'b0, 1'b1, 1'b0, a + 2, w + 1, r);
                        chk("R9 release after closing hold cycle", {31'd0, own_bus}, 32'd0);
                        release_req = 1'b0;
                        tick();
                    end
                    chk("R8/R9 idle between scenarios", {30'd0, own_bus, bid}, 32'd0);
                end
            end
        end

        for (int k = 0; k < 2; k++) begin
            for (int ret = 0; ret < 2; ret++) begin
                do_cycle(1'b1, k, ret[0], 1'b0, 1'b1, 16'h2200 + 16'(k * 2 + ret),
                         16'h0F0F, 16'hF0F0);
                do_cycle(1'b1, 2, 1'b0, 1'b1, 1'b0, 16'h3300, 16'h0, 16'h0);
                chk("R10 retain cleared by abort", {31'd0, own_bus}, 32'd0);
                tick();
            end
        end

        summary();
    end
endmodule